// File: doc/BRIEF.md
# IOT Peripheral Bus Controller

This block is the device end of a small processor I/O bus on which software does most of the control work. The processor puts a device number on a shared 6-bit select bus and then fires up to three command pulses, one after another. The block compares the select bus with a device code fixed at build time. Each pulse that arrives while the code matches becomes a local command. One pulse tests the device's done flag through a single skip line. One clears the flag. One loads a 12-bit device register from the processor's output data. When read-back is enabled at build time, that last pulse also returns the register's previous contents on the input data bus.

The device side raises the done flag with a synchronous strobe. The flag is ORed onto a shared interrupt request line, and the same flag is the skip condition. Polling software can therefore find the interrupting device by issuing skip tests to each device in turn. An unselected device drives zeros on the input data bus and on the skip line, so the outputs of several devices can be ORed together.

Top module: `iot_dev_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the done flag, `dev_reg`, `io_din` and `io_skip` all become 0. With `irq_in` low, `irq_out` is then also 0.
- R2: When `io_sel` differs from `DEV_CODE` (default 6'h2B), the pulses have no effect. The flag and `dev_reg` keep their values, and `io_skip` and `io_din` are 0 in the next cycle.
- R3: A pulse on `io_p1` with a matching select sets `io_skip` to 1 in the next cycle if the flag was set before that edge. Otherwise `io_skip` is 0 in that cycle. In every cycle not preceded by a matched `io_p1`, `io_skip` is 0.
- R4: A pulse on `io_p2` with a matching select clears the flag at that edge, unless `dev_done` is high in the same cycle.
- R5: `dev_done` high at an edge sets the flag, and this takes priority over a clear in the same cycle.
- R6: A pulse on `io_p4` with a matching select loads `io_dout` into `dev_reg`, which is visible in the next cycle. Without such a pulse, `dev_reg` holds its value.
- R7: With `READ_EN`=1, `io_din` in the cycle after a matched `io_p4` carries the `dev_reg` value from before that load. In all other cycles `io_din` is 0.
- R8: `irq_out` is the OR of the registered flag and `irq_in`. The flag contribution appears in the cycle after the `dev_done` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel | input | 6 | Shared device select bus |
| io_p1 | input | 1 | Command pulse 1 (skip test) |
| io_p2 | input | 1 | Command pulse 2 (clear flag) |
| io_p4 | input | 1 | Command pulse 4 (load and read register) |
| io_dout | input | 12 | Data from the processor to the device |
| dev_done | input | 1 | Device side strobe that sets the flag |
| irq_in | input | 1 | Incoming shared interrupt request |
| io_din | output | 12 | Data to the processor, zero unless selected |
| io_skip | output | 1 | Skip response to the processor |
| irq_out | output | 1 | Shared interrupt request, including this device |
| dev_reg | output | 12 | Device register contents |

## Verification
The bench drives the select bus with the device's own code, with a code one bit away from it, and with random codes. This separates true address decoding from partial matching. Each pulse is tried with the flag both set and clear. `dev_done` is placed in the same cycle as a clear, which shows whether the set takes priority. Loads of all-ones followed by all-zeros show that the read returns the pre-load value rather than the new one. Randomly toggling `irq_in` separates this device's own request from the shared line.

// File: rtl/iot_pkg.sv
package iot_pkg;
  // Local commands formed from select match and pulse lines
  typedef struct packed {
    logic test;   // pulse 1
    logic clear;  // pulse 2
    logic load;   // pulse 4
  } iot_cmd_t;
endpackage

// File: rtl/iot_sel_decode.sv
module iot_sel_decode
  import iot_pkg::*;
#(
  parameter int SEL_W = 6,
  parameter logic [SEL_W-1:0] DEV_CODE = 6'h2B
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             p1,
  input  logic             p2,
  input  logic             p4,
  output iot_cmd_t         cmd
);
  logic hit;

  assign hit       = (sel == DEV_CODE);
  assign cmd.test  = hit & p1;
  assign cmd.clear = hit & p2;
  assign cmd.load  = hit & p4;
endmodule

// File: rtl/iot_flag_unit.sv
module iot_flag_unit
  import iot_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  iot_cmd_t cmd,
  input  logic     set_i,
  output logic     flag_q,
  output logic     skip_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      skip_q <= cmd.test & flag_q;
      if (set_i)
        flag_q <= 1'b1;
      else if (cmd.clear)
        flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/iot_data_port.sv
module iot_data_port #(
  parameter int DATA_W  = 12,
  parameter bit READ_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] reg_q,
  output logic [DATA_W-1:0] din_q
);
  logic [DATA_W-1:0] din_next;

  // Per-bit AND gating of the read path; unselected gives zeros
  for (genvar i = 0; i < DATA_W; i++) begin : g_rd
    if (READ_EN) begin : g_on
      assign din_next[i] = load & reg_q[i];
    end else begin : g_off
      assign din_next[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q <= '0;
      din_q <= '0;
    end else begin
      din_q <= din_next;
      if (load)
        reg_q <= dout;
    end
  end
endmodule

// File: rtl/iot_dev_ctrl.sv
module iot_dev_ctrl
  import iot_pkg::*;
#(
  parameter int SEL_W  = 6,
  parameter int DATA_W = 12,
  parameter logic [SEL_W-1:0] DEV_CODE = 6'h2B,
  parameter bit READ_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  io_sel,
  input  logic              io_p1,
  input  logic              io_p2,
  input  logic              io_p4,
  input  logic [DATA_W-1:0] io_dout,
  input  logic              dev_done,
  input  logic              irq_in,
  output logic [DATA_W-1:0] io_din,
  output logic              io_skip,
  output logic              irq_out,
  output logic [DATA_W-1:0] dev_reg
);
  iot_cmd_t cmd;
  logic     flag_q;

  iot_sel_decode #(.SEL_W(SEL_W), .DEV_CODE(DEV_CODE)) u_dec (
    .sel(io_sel), .p1(io_p1), .p2(io_p2), .p4(io_p4), .cmd(cmd)
  );

  iot_flag_unit u_flag (
    .clk(clk), .rst(rst), .cmd(cmd), .set_i(dev_done),
    .flag_q(flag_q), .skip_q(io_skip)
  );

  iot_data_port #(.DATA_W(DATA_W), .READ_EN(READ_EN)) u_data (
    .clk(clk), .rst(rst), .load(cmd.load), .dout(io_dout),
    .reg_q(dev_reg), .din_q(io_din)
  );

  // Contribution to the shared request line
  assign irq_out = flag_q | irq_in;
endmodule

// File: rtl/iot_dev_ctrl_chk.sv
module iot_dev_ctrl_chk #(
  parameter int SEL_W  = 6,
  parameter int DATA_W = 12,
  parameter logic [SEL_W-1:0] DEV_CODE = 6'h2B
) (
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  io_sel,
  input logic              io_p1,
  input logic              io_p2,
  input logic              io_p4,
  input logic [DATA_W-1:0] io_dout,
  input logic              dev_done,
  input logic [DATA_W-1:0] io_din,
  input logic              io_skip,
  input logic [DATA_W-1:0] dev_reg,
  input logic              flag_q
);
  logic sel_hit;
  assign sel_hit = (io_sel == DEV_CODE);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!flag_q && dev_reg == '0 && io_din == '0 && !io_skip));

  // R2
  unsel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_hit |=> (!io_skip && io_din == '0 && $stable(dev_reg)));

  // R3
  skip_tracks_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_hit && io_p1) |=> (io_skip == $past(flag_q)));

  // R4
  clear_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_hit && io_p2 && !dev_done) |=> !flag_q);

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    dev_done |=> flag_q);

  // R6
  load_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_hit && io_p4) |=> (dev_reg == $past(io_dout)));

  // R3
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({io_p1, io_p2, io_p4}));
endmodule

bind iot_dev_ctrl iot_dev_ctrl_chk #(
  .SEL_W(SEL_W), .DATA_W(DATA_W), .DEV_CODE(DEV_CODE)
) u_chk (
  .clk(clk), .rst(rst), .io_sel(io_sel), .io_p1(io_p1), .io_p2(io_p2),
  .io_p4(io_p4), .io_dout(io_dout), .dev_done(dev_done), .io_din(io_din),
  .io_skip(io_skip), .dev_reg(dev_reg), .flag_q(flag_q)
);

// File: tb/iot_dev_ctrl_test.sv
`timescale 1ns/1ps
module iot_dev_ctrl_test;
  localparam logic [5:0] CODE = 6'h2B;

  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  io_sel;
  logic        io_p1, io_p2, io_p4, dev_done, irq_in;
  logic [11:0] io_dout, io_din, dev_reg;
  logic        io_skip, irq_out;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  // bench model
  logic        m_flag = 1'b0;
  logic [11:0] m_reg  = '0;

  always #2 clk = ~clk;  // 250 MHz

  iot_dev_ctrl uut (
    .clk(clk), .rst(rst), .io_sel(io_sel), .io_p1(io_p1), .io_p2(io_p2),
    .io_p4(io_p4), .io_dout(io_dout), .dev_done(dev_done), .irq_in(irq_in),
    .io_din(io_din), .io_skip(io_skip), .irq_out(irq_out), .dev_reg(dev_reg)
  );

  task automatic chk(string tag, string what, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic f_flag(logic hit, logic p2, logic dn, logic cur);
    return dn ? 1'b1 : ((hit & p2) ? 1'b0 : cur);
  endfunction

  function automatic logic [11:0] f_din(logic hit, logic p4, logic [11:0] r);
    return (hit & p4) ? r : 12'h000;
  endfunction

  task automatic step(string tag, logic [5:0] s, logic a, logic b, logic c,
                      logic [11:0] d, logic dn, logic ir);
    logic hit, e_skip, e_flag;
    logic [11:0] e_reg, e_din;
    @(negedge clk);
    io_sel = s; io_p1 = a; io_p2 = b; io_p4 = c;
    io_dout = d; dev_done = dn; irq_in = ir;
    hit    = (s == CODE);
    e_skip = hit & a & m_flag;
    e_din  = f_din(hit, c, m_reg);
    e_reg  = (hit & c) ? d : m_reg;
    e_flag = f_flag(hit, b, dn, m_flag);
    @(posedge clk);
    #1;
    chk(tag, "skip", {11'b0, io_skip}, {11'b0, e_skip});
    chk(tag, "din", io_din, e_din);
    chk(tag, "reg", dev_reg, e_reg);
    chk(tag, "irq", {11'b0, irq_out}, {11'b0, e_flag | ir});
    m_flag = e_flag;
    m_reg  = e_reg;
  endtask

  task automatic do_reset(int n);
    @(negedge clk);
    rst = 1'b1; io_sel = '0; io_p1 = 0; io_p2 = 0; io_p4 = 0;
    io_dout = 12'hABC; dev_done = 1'b1; irq_in = 1'b0;
    repeat (n) @(posedge clk);
    #1;
    // R1: reset wins even over dev_done
    chk("R1", "reg", dev_reg, 12'h000);
    chk("R1", "din", io_din, 12'h000);
    chk("R1", "skip", {11'b0, io_skip}, 12'h000);
    chk("R1", "irq", {11'b0, irq_out}, 12'h000);
    @(negedge clk);
    rst = 1'b0; dev_done = 1'b0;
    m_flag = 1'b0; m_reg = '0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5EED;
    void'($urandom(seed));
    rst = 1'b1;
    do_reset(3);
    // R3: skip test with flag clear gives no skip
    step("R3", CODE, 1, 0, 0, 12'h000, 0, 0);
    // R5/R8: done raises flag and request
    step("R5", 6'h00, 0, 0, 0, 12'h000, 1, 0);
    step("R8", 6'h00, 0, 0, 0, 12'h000, 0, 0);
    // R3: skip with flag set
    step("R3", CODE, 1, 0, 0, 12'h000, 0, 0);
    // R2: neighbour code clears nothing, loads nothing
    step("R2", CODE ^ 6'h01, 0, 1, 0, 12'h000, 0, 0);
    step("R2", CODE ^ 6'h20, 0, 0, 1, 12'h5A5, 0, 0);
    step("R2", CODE ^ 6'h04, 1, 0, 0, 12'h000, 0, 0);
    // R5: clear and set same cycle, set wins
    step("R5", CODE, 0, 1, 0, 12'h000, 1, 0);
    // R4: clear alone
    step("R4", CODE, 0, 1, 0, 12'h000, 0, 0);
    step("R4", CODE, 1, 0, 0, 12'h000, 0, 0);
    // R6/R7: load all ones, then all zeros returns all ones
    step("R6", CODE, 0, 0, 1, 12'hFFF, 0, 0);
    step("R7", CODE, 0, 0, 1, 12'h000, 0, 0);
    step("R7", CODE, 0, 0, 1, 12'h3C3, 0, 0);
    step("R7", CODE, 0, 0, 0, 12'hFFF, 0, 0);
    // R8: shared request passes through with flag clear
    step("R8", 6'h11, 0, 0, 0, 12'h000, 0, 1);
    // one IOT instruction: pulses 1, 2, 4 in order
    step("R5", 6'h00, 0, 0, 0, 12'h000, 1, 0);
    step("R3", CODE, 1, 0, 0, 12'h000, 0, 0);
    step("R4", CODE, 0, 1, 0, 12'h000, 0, 0);
    step("R6", CODE, 0, 0, 1, 12'h777, 0, 0);
    // R1: reset mid-run with state present
    step("R5", 6'h00, 0, 0, 0, 12'h000, 1, 0);
    do_reset(1);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] s;
      int pk;
      logic a, b, c;
      s  = ($urandom % 2) ? CODE : 6'($urandom);
      pk = $urandom % 4;
      a = (pk == 1); b = (pk == 2); c = (pk == 3);
      step((s == CODE) ? "R3R4R6R7" : "R2", s, a, b, c, 12'($urandom),
           ($urandom % 4) == 0, ($urandom % 8) == 0);
    end
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule